// File: doc/BRIEF.md
# Serial Two-Threshold Ternary Activation Unit

This block turns a vector of signed neuron sums, produced in parallel by an accumulator array, into a stream of ternary activations. One pulse on `load` captures the whole vector of sums into a holding register. The block then visits the neurons in index order, one per clock. For each neuron it compares that neuron's sum against the neuron's own lower and upper thresholds and emits a 2-bit ternary code. Each code is tagged with the neuron index, and the final neuron of the vector is flagged. The stream can feed the next layer as its serial input.

Each neuron's threshold pair sits in a small memory that can be rewritten at any time through a write port. When a vector is loaded, the thresholds are copied along with the sums. As a result, a write made while a vector is being serialized only applies from the next vector on. Only one comparator pair and one code multiplexer are used, and they are shared across all neurons. While a vector is in flight, the accumulator array is free to build the next one.

Top module: `tern_step_serializer`

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0, `out_idx` is 0 and `out_act` is 2'b00, and they stay so until a load is accepted.
- R2: A `load` sampled high while no vector is in flight is accepted. In the next cycle neuron 0 appears with `out_valid` high. Neurons 1 to N-1 then follow, one per cycle, in increasing index order with no gaps.
- R3: When the sum is strictly greater than the neuron's upper threshold, `out_act` is +1, coded 2'b01.
- R4: When the sum is strictly less than the neuron's lower threshold, `out_act` is -1, coded 2'b11.
- R5: When the sum lies between the lower and upper thresholds, both bounds included, `out_act` is 0, coded 2'b00.
- R6: The sums and thresholds are compared as signed two's complement values of `SUM_W` bits.
- R7: A write with `thr_we` high stores `thr_lo` and `thr_hi` as the threshold pair of neuron `thr_addr`. Each neuron is judged against its own pair.
- R8: `out_last` is high exactly in the cycle that carries neuron N-1.
- R9: A `load` sampled while a vector is in flight, including during its final cycle, is ignored. The stream carries the original sums, and no new vector starts afterwards.
- R10: Changes on `sums` after a load has been accepted do not affect the vector in flight.
- R11: A threshold write made while a vector is in flight does not affect that vector. The write applies to every vector loaded afterwards.
- R12: Whenever `out_valid` is low, `out_act` is 2'b00 and `out_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_we | input | 1 | Threshold write enable |
| thr_addr | input | IDX_W | Neuron whose thresholds are written |
| thr_lo | input | SUM_W | Lower threshold, signed |
| thr_hi | input | SUM_W | Upper threshold, signed |
| load | input | 1 | Capture `sums` and start a vector |
| sums | input | N*SUM_W | Signed sums; neuron i occupies bits [i*SUM_W +: SUM_W] |
| out_valid | output | 1 | Stream entry is valid |
| out_last | output | 1 | Entry is the last neuron of the vector |
| out_idx | output | IDX_W | Neuron index of the entry |
| out_act | output | 2 | Ternary activation, two's complement |

## Verification
An accepted `load` shows neuron 0 on the outputs one clock later. Neuron k follows k clocks after that, and the outputs go quiet one clock after the `out_last` cycle. The bench drives inputs just after a rising edge and samples at each falling edge, stepping one neuron per sample. A threshold write or a `load` raised during a vector is applied at the falling edge of a known neuron. The bench then checks the rest of that vector against the old expectations and the following vector against the new ones.

// File: rtl/tern_pkg.sv
package tern_pkg;
  typedef logic [1:0] tern_t;
  localparam tern_t TERN_POS  = 2'b01;
  localparam tern_t TERN_ZERO = 2'b00;
  localparam tern_t TERN_NEG  = 2'b11;
endpackage

// File: rtl/tern_thr_bank.sv
module tern_thr_bank #(
  parameter int N     = 8,
  parameter int SUM_W = 12,
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_addr,
  input  logic [SUM_W-1:0]   wr_lo,
  input  logic [SUM_W-1:0]   wr_hi,
  output logic [N*SUM_W-1:0] lo_flat,
  output logic [N*SUM_W-1:0] hi_flat
);
  for (genvar i = 0; i < N; i++) begin : g_entry
    logic             hit;
    logic [SUM_W-1:0] lo_q, hi_q;
    assign hit = wr_en && (wr_addr == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (hit) begin
        lo_q <= wr_lo;
        hi_q <= wr_hi;
      end
    end
    assign lo_flat[i*SUM_W +: SUM_W] = lo_q;
    assign hi_flat[i*SUM_W +: SUM_W] = hi_q;
  end
endmodule

// File: rtl/tern_hold.sv
module tern_hold #(
  parameter int N     = 8,
  parameter int SUM_W = 12,
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic [N*SUM_W-1:0] sum_in,
  input  logic [N*SUM_W-1:0] lo_in,
  input  logic [N*SUM_W-1:0] hi_in,
  input  logic [IDX_W-1:0]   sel,
  output logic [SUM_W-1:0]   sel_sum,
  output logic [SUM_W-1:0]   sel_lo,
  output logic [SUM_W-1:0]   sel_hi
);
  logic [N*SUM_W-1:0] sum_q, lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (cap_en) begin
      sum_q <= sum_in;
      lo_q  <= lo_in;
      hi_q  <= hi_in;
    end
  end

  always_comb begin
    sel_sum = sum_q[sel*SUM_W +: SUM_W];
    sel_lo  = lo_q[sel*SUM_W +: SUM_W];
    sel_hi  = hi_q[sel*SUM_W +: SUM_W];
  end
endmodule

// File: rtl/tern_step.sv
module tern_step
  import tern_pkg::*;
#(
  parameter int SUM_W = 12
) (
  input  logic [SUM_W-1:0] sum,
  input  logic [SUM_W-1:0] lo,
  input  logic [SUM_W-1:0] hi,
  output tern_t            act
);
  logic above, below;
  always_comb begin
    above = $signed(sum) > $signed(hi);
    below = $signed(sum) < $signed(lo);
    if (above)      act = TERN_POS;
    else if (below) act = TERN_NEG;
    else            act = TERN_ZERO;
  end
endmodule

// File: rtl/tern_step_serializer.sv
module tern_step_serializer
  import tern_pkg::*;
#(
  parameter int N     = 8,
  parameter int SUM_W = 12,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               thr_we,
  input  logic [IDX_W-1:0]   thr_addr,
  input  logic [SUM_W-1:0]   thr_lo,
  input  logic [SUM_W-1:0]   thr_hi,
  input  logic               load,
  input  logic [N*SUM_W-1:0] sums,
  output logic               out_valid,
  output logic               out_last,
  output logic [IDX_W-1:0]   out_idx,
  output logic [1:0]         out_act
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  logic               active_q, active_d;
  logic [IDX_W-1:0]   cnt_q, cnt_d;
  logic               accept, at_last;
  logic [N*SUM_W-1:0] bank_lo, bank_hi;
  logic [SUM_W-1:0]   cur_sum, cur_lo, cur_hi;
  tern_t              cur_act;

  tern_thr_bank #(.N(N), .SUM_W(SUM_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(thr_we), .wr_addr(thr_addr),
    .wr_lo(thr_lo), .wr_hi(thr_hi), .lo_flat(bank_lo), .hi_flat(bank_hi)
  );

  tern_hold #(.N(N), .SUM_W(SUM_W), .IDX_W(IDX_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap_en(accept), .sum_in(sums),
    .lo_in(bank_lo), .hi_in(bank_hi), .sel(cnt_q),
    .sel_sum(cur_sum), .sel_lo(cur_lo), .sel_hi(cur_hi)
  );

  tern_step #(.SUM_W(SUM_W)) u_step (
    .sum(cur_sum), .lo(cur_lo), .hi(cur_hi), .act(cur_act)
  );

  always_comb begin
    accept   = load && !active_q;
    at_last  = active_q && (cnt_q == LAST_IDX);
    active_d = active_q;
    cnt_d    = cnt_q;
    if (accept) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (at_last) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (active_q) begin
      cnt_d    = cnt_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  always_comb begin
    out_valid = active_q;
    out_last  = at_last;
    out_idx   = active_q ? cnt_q : '0;
    out_act   = active_q ? cur_act : TERN_ZERO;
  end
endmodule

// File: rtl/tern_step_serializer_chk.sv
module tern_step_serializer_chk #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic             out_valid,
  input logic             out_last,
  input logic [IDX_W-1:0] out_idx,
  input logic [1:0]       out_act
);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !out_valid) |=> (out_valid && out_idx == '0));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> (out_valid && out_idx == IDX_W'($past(out_idx) + IDX_W'(1))));

  assert_last_is_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_idx == IDX_W'(N - 1)));

  assert_final_is_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_idx == IDX_W'(N - 1)) |-> out_last);

  assert_end_ignores_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_act != 2'b10);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_act == 2'b00 && out_idx == '0));
endmodule

bind tern_step_serializer tern_step_serializer_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .out_valid(out_valid),
  .out_last(out_last), .out_idx(out_idx), .out_act(out_act)
);

// File: tb/tern_step_serializer_tb.sv
module tern_step_serializer_tb;
  localparam int N     = 8;
  localparam int W     = 12;
  localparam int IW    = 3;
  localparam int ENT   = 16;

  // expected codes: +1 = 01, 0 = 00, -1 = 11
  localparam logic signed [W-1:0] T_LO  [ENT] = '{-10, -10, -10, -10, 0, 0, 0, -5,
                                                  -100, -100, -100, 50, 50, -2048, -2048, 0};
  localparam logic signed [W-1:0] T_HI  [ENT] = '{10, 10, 10, 10, 0, 0, 0, 5,
                                                  -50, -50, -50, 100, 100, 2047, 2047, 5};
  localparam logic signed [W-1:0] T_SUM [ENT] = '{11, 10, -10, -11, 0, 1, -1, 2047,
                                                  -60, -49, -101, 49, 75, -2048, 2047, -2048};
  localparam logic [1:0]          T_EXP [ENT] = '{2'b01, 2'b00, 2'b00, 2'b11, 2'b00, 2'b01, 2'b11, 2'b01,
                                                  2'b00, 2'b01, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11};

  logic clk = 1'b0;
  logic rst_n;
  logic thr_we;
  logic [IW-1:0] thr_addr;
  logic [W-1:0] thr_lo, thr_hi;
  logic load;
  logic [N*W-1:0] sums;
  logic out_valid, out_last;
  logic [IW-1:0] out_idx;
  logic [1:0] out_act;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [1:0] exp_v [N];

  always #2.5 clk = ~clk;

  tern_step_serializer #(.N(N), .SUM_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_addr(thr_addr),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .load(load), .sums(sums),
    .out_valid(out_valid), .out_last(out_last), .out_idx(out_idx), .out_act(out_act)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_thr(input int idx, input logic [W-1:0] lo, input logic [W-1:0] hi);
    @(posedge clk); #1;
    thr_we = 1'b1; thr_addr = IW'(idx); thr_lo = lo; thr_hi = hi;
    @(posedge clk); #1;
    thr_we = 1'b0;
  endtask

  // mode 0: plain; 1: load + new sums while busy (R9, R10); 2: threshold write to neuron 6 while busy (R11)
  task automatic run_vec(input int mode, input string req);
    @(posedge clk); #1;
    load = 1'b1;
    @(posedge clk); #1;
    load = 1'b0;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      check(out_valid === 1'b1, {req, " valid (R2)"}, int'(out_valid), 1);
      check(out_idx === IW'(k), {req, " index order (R2)"}, int'(out_idx), k);
      check(out_act === exp_v[k], {req, " activation (R3 R4 R5 R6 R7)"}, int'(out_act), int'(exp_v[k]));
      check(out_last === (k == N - 1), {req, " last flag (R8)"}, int'(out_last), int'(k == N - 1));
      if (mode == 1 && k == 2) begin
        load = 1'b1; sums = '0;
      end
      if (mode == 1 && k == N - 1) load = 1'b1;
      if (mode == 2 && k == 1) begin
        thr_we = 1'b1; thr_addr = IW'(6); thr_lo = -12'sd5; thr_hi = 12'sd5;
      end
      if (mode == 2 && k == 2) thr_we = 1'b0;
    end
    @(negedge clk);
    load = 1'b0;
    check(out_valid === 1'b0, {req, " ends after last, load ignored (R9)"}, int'(out_valid), 0);
    @(negedge clk);
    check(out_valid === 1'b0 && out_act === 2'b00 && out_idx === '0,
          {req, " idle outputs quiet (R12)"}, int'(out_act), 0);
  endtask

  task automatic setup_group(input int base);
    for (int i = 0; i < N; i++) begin
      write_thr(i, T_LO[base + i], T_HI[base + i]);
      exp_v[i] = T_EXP[base + i];
    end
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) sums[i*W +: W] = T_SUM[base + i];
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; thr_we = 1'b0; thr_addr = '0; thr_lo = '0; thr_hi = '0;
    load = 1'b0; sums = '0;
    #12;
    @(negedge clk);
    check(out_valid === 1'b0 && out_last === 1'b0, "reset flags (R1)", int'(out_valid), 0);
    check(out_act === 2'b00 && out_idx === '0, "reset data (R1)", int'(out_act), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "idle without load (R1)", int'(out_valid), 0);

    // table walk: each group of N entries is one vector
    for (int g = 0; g < ENT / N; g++) begin
      setup_group(g * N);
      run_vec(0, "table");
    end

    // load and new sums during serialization are ignored (R9, R10)
    setup_group(N);
    run_vec(1, "busy load R9 R10");

    // threshold write mid-vector applies only to the following vector (R11)
    setup_group(0);
    run_vec(2, "thr write in flight R11");
    exp_v[6] = 2'b00;  // neuron 6: sum -1 now inside [-5, 5]
    run_vec(0, "thr write next vector R11");

    // per-neuron thresholds: same sum, different pairs (R7)
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) sums[i*W +: W] = 12'sd20;
    for (int i = 0; i < N; i++) begin
      write_thr(i, W'(i * 8 - 30), W'(i * 8 - 12));
      exp_v[i] = (20 > i * 8 - 12) ? 2'b01 : ((20 < i * 8 - 30) ? 2'b11 : 2'b00);
    end
    run_vec(0, "own thresholds R7");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule